// File: doc/BRIEF.md
# Double-Buffered Transmit Bit Serializer

This block sits between a host that writes whole bytes and a serial line that must see one bit per fixed period. The host deposits bytes into a pair of holding slots whenever the ready flag is high. A programmable bit-rate generator then emits each byte most significant bit first, one bit every `rate_div + 1` clock cycles. Because two slots exist, the host can post the following byte while the current one is still leaving, and consecutive bytes join without a gap bit.

A small state machine sequences the serial side. Its three states are **IDLE**, **SHIFT** and **STARVE**:
- **start**: IDLE moves to SHIFT when `tx_en` is high and a byte is held.
- **chain**: SHIFT stays in SHIFT when a byte ends and another is waiting.
- **starve**: SHIFT moves to STARVE when a byte ends with nothing waiting. The line keeps the last bit and `underrun` is raised.
- **resume**: STARVE moves to SHIFT at the next bit boundary where a byte is held.
- **halt**: IDLE, SHIFT or STARVE moves to IDLE whenever `tx_en` is low.

Top module: `txbit_serializer`

## Requirements
- R1: After reset, `tx_bit` is 0, `ready` is 1, `underrun` is 0 and both slots are empty.
- R2: `ready` is high exactly when fewer than two bytes are held. A write while `ready` is low is discarded, and that byte is never transmitted.
- R3: Each byte leaves most significant bit first, bit 7 down to bit 0.
- R4: Every bit lasts `rate_div + 1` clock cycles. The first bit of a byte appears on the clock edge after the one at which `tx_en` is high with a byte held in IDLE.
- R5: When a byte ends and a second byte is held, the second byte's bit 7 follows on the very next bit boundary, with no gap.
- R6: When a byte ends and no other byte is held, `underrun` rises and `tx_bit` keeps the last bit. A byte written later starts at the next bit boundary, counted from the underrun edge, and `underrun` stays high.
- R7: When `tx_en` is low, the block returns to IDLE on the next edge, `underrun` clears and `tx_bit` holds. A partly sent byte stays held and restarts from bit 7 when `tx_en` rises again.
- R8: In IDLE with `tx_en` high and no byte held, nothing is sent, `tx_bit` holds and `underrun` stays low.
- R9: A byte keeps its slot until its last bit period ends. With two bytes held, `ready` rises on the edge where the first byte's bit 0 period ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe, one cycle per byte |
| wr_data | input | 8 | Byte to be queued |
| rate_div | input | 8 | Bit period minus one, in clock cycles |
| tx_en | input | 1 | Transmit enable |
| tx_bit | output | 1 | Serial data out |
| ready | output | 1 | At least one slot is free |
| underrun | output | 1 | Line ran dry while enabled; clears when `tx_en` is low |

## Verification
The bench targets several corner cases. The first is the bit boundary between two queued bytes. A design with an off-by-one in the hand-over would insert or drop a bit there, and the expected stream would slip. The second is a third write while both slots are full. A design that did not drop it would overwrite a queued byte or send extra bits. The third covers entering and leaving STARVE, where a design could miss the raise of `underrun`, or restart at the wrong phase of the rate generator. The last drops `tx_en` in mid-byte. A faulty design would resume from the interrupted bit instead of bit 7, or would keep `underrun` set.

// File: rtl/txbit_pkg.sv
package txbit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_STARVE = 2'd2
    } tx_state_e;

    localparam int unsigned SLOT_NUM = 2;
    localparam int unsigned FILL_W   = 2;

endpackage

// File: rtl/txbit_rate_gen.sv
module txbit_rate_gen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] rate_div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == rate_div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // R4
    period_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> (cnt_q == $past(cnt_q) + DIV_W'(1)));

    // R4
    period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));

endmodule

// File: rtl/txbit_byte_buf.sv
module txbit_byte_buf
    import txbit_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop,
    output logic [DATA_W-1:0] front,
    output logic [DATA_W-1:0] second,
    output logic [FILL_W-1:0] fill,
    output logic              ready
);

    logic [DATA_W-1:0] slot_q [SLOT_NUM];
    logic              wr_ptr_q;
    logic              rd_ptr_q;
    logic [FILL_W-1:0] fill_q;
    logic              wr_ok;

    assign ready  = (fill_q != FILL_W'(SLOT_NUM));
    assign wr_ok  = wr_en && ready;
    assign fill   = fill_q;
    assign front  = slot_q[rd_ptr_q];
    assign second = slot_q[~rd_ptr_q];

    for (genvar g = 0; g < SLOT_NUM; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_ok && (wr_ptr_q == 1'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= 1'b0;
            rd_ptr_q <= 1'b0;
            fill_q   <= '0;
        end else begin
            if (wr_ok) begin
                wr_ptr_q <= ~wr_ptr_q;
            end
            if (pop) begin
                rd_ptr_q <= ~rd_ptr_q;
            end
            unique case ({wr_ok, pop})
                2'b10:   fill_q <= fill_q + FILL_W'(1);
                2'b01:   fill_q <= fill_q - FILL_W'(1);
                default: fill_q <= fill_q;
            endcase
        end
    end

    // R2
    full_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && wr_en && !pop) |=>
            (!ready && $stable(slot_q[0]) && $stable(slot_q[1])));

    // R9
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (fill_q != '0));

endmodule

// File: rtl/txbit_ser_fsm.sv
module txbit_ser_fsm
    import txbit_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              tick,
    input  logic [FILL_W-1:0] fill,
    input  logic [DATA_W-1:0] front,
    input  logic [DATA_W-1:0] second,
    output logic              pop,
    output logic              run,
    output logic              tx_bit,
    output logic              underrun
);

    localparam int unsigned     IDX_W   = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);

    tx_state_e         state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  idx_dn;
    logic              held;
    logic              queued;
    logic              byte_end;

    assign held     = (fill != '0);
    assign queued   = (fill == FILL_W'(SLOT_NUM));
    assign idx_dn   = idx_q - IDX_W'(1);
    assign byte_end = (state_q == ST_SHIFT) && tx_en && tick && (idx_q == '0);
    assign pop      = byte_end;
    assign run      = (state_q != ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_en && held) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (!tx_en)                  state_d = ST_IDLE;
                else if (byte_end && !queued) state_d = ST_STARVE;
            end
            ST_STARVE: begin
                if (!tx_en)            state_d = ST_IDLE;
                else if (tick && held) state_d = ST_SHIFT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_bit   <= 1'b0;
            idx_q    <= TOP_IDX;
            underrun <= 1'b0;
        end else if (!tx_en) begin
            underrun <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (held) begin
                        tx_bit <= front[DATA_W-1];
                        idx_q  <= TOP_IDX;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (idx_q != '0) begin
                            tx_bit <= front[idx_dn];
                            idx_q  <= idx_dn;
                        end else if (queued) begin
                            tx_bit <= second[DATA_W-1];
                            idx_q  <= TOP_IDX;
                        end else begin
                            underrun <= 1'b1;
                        end
                    end
                end
                ST_STARVE: begin
                    if (tick && held) begin
                        tx_bit <= front[DATA_W-1];
                        idx_q  <= TOP_IDX;
                    end
                end
                default: begin
                    underrun <= 1'b0;
                end
            endcase
        end
    end

    // R4
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_IDLE) && !tick) |=> $stable(tx_bit));

    // R5
    no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_end && queued) |=>
            ((state_q == ST_SHIFT) && (tx_bit == $past(second[DATA_W-1]))));

    // R6
    underrun_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_end && !queued) |=>
            (underrun && (state_q == ST_STARVE) && $stable(tx_bit)));

    // R7
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> ((state_q == ST_IDLE) && !underrun && $stable(tx_bit)));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && !held) |=> ($stable(tx_bit) && !underrun));

endmodule

// File: rtl/txbit_serializer.sv
module txbit_serializer
    import txbit_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DIV_W-1:0]  rate_div,
    input  logic              tx_en,
    output logic              tx_bit,
    output logic              ready,
    output logic              underrun
);

    logic              tick;
    logic              run;
    logic              pop;
    logic [FILL_W-1:0] fill;
    logic [DATA_W-1:0] front;
    logic [DATA_W-1:0] second;

    txbit_rate_gen #(
        .DIV_W (DIV_W)
    ) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .rate_div (rate_div),
        .tick     (tick)
    );

    txbit_byte_buf #(
        .DATA_W (DATA_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pop     (pop),
        .front   (front),
        .second  (second),
        .fill    (fill),
        .ready   (ready)
    );

    txbit_ser_fsm #(
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .tick     (tick),
        .fill     (fill),
        .front    (front),
        .second   (second),
        .pop      (pop),
        .run      (run),
        .tx_bit   (tx_bit),
        .underrun (underrun)
    );

    // R9
    ready_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !pop) |=> !ready);

endmodule

// File: tb/txbit_serializer_tb.sv
module txbit_serializer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 4;
    // {rate_div, first byte, second byte, byte written while full}
    localparam logic [31:0] VEC [NVEC] = '{
        32'h00_A5_3C_77,
        32'h01_80_01_EE,
        32'h03_FF_00_5A,
        32'h06_5A_C3_11
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rate_div = '0;
    logic       tx_en = 1'b0;
    logic       tx_bit;
    logic       ready;
    logic       underrun;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txbit_serializer u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rate_div (rate_div),
        .tx_en    (tx_en),
        .tx_bit   (tx_bit),
        .ready    (ready),
        .underrun (underrun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] stream;
        int          per;
        logic        last_bit;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 tx_bit", 32'(tx_bit), 0);
        chk("R1 ready", 32'(ready), 1);
        chk("R1 underrun", 32'(underrun), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after release", 32'(ready), 1);

        last_bit = 1'b0;
        for (int v = 0; v < NVEC; v++) begin
            rate_div = VEC[v][31:24];
            per      = int'(VEC[v][31:24]) + 1;
            stream   = VEC[v][23:8];
            wr(VEC[v][23:16]);
            chk("R2 ready after one byte", 32'(ready), 1);
            wr(VEC[v][15:8]);
            chk("R2 ready full", 32'(ready), 0);
            wr(VEC[v][7:0]);
            tx_en = 1'b1;
            @(negedge clk);
            for (int c = 0; c < 16 * per; c++) begin
                chk("R3/R4/R5 bit", 32'(tx_bit), 32'(stream[15 - c / per]));
                chk("R9 ready", 32'(ready), 32'(c >= 8 * per));
                chk("R6 no early underrun", 32'(underrun), 0);
                @(negedge clk);
            end
            chk("R6 underrun raised", 32'(underrun), 1);
            chk("R6 last bit held", 32'(tx_bit), 32'(stream[0]));
            chk("R2 dropped byte absent", 32'(ready), 1);
            last_bit = stream[0];
            tx_en = 1'b0;
            @(negedge clk);
            chk("R7 underrun cleared", 32'(underrun), 0);
        end

        // R8: enabled with nothing held
        rate_div = 8'd2;
        tx_en    = 1'b1;
        repeat (5) @(negedge clk);
        chk("R8 idle underrun", 32'(underrun), 0);
        chk("R8 idle bit held", 32'(tx_bit), 32'(last_bit));
        wr(8'h6A);
        chk("R8 still idle on write edge", 32'(tx_bit), 32'(last_bit));
        @(negedge clk);
        chk("R4 first bit one edge later", 32'(tx_bit), 0);
        repeat (3) @(negedge clk);
        chk("R3 bit6 of 6A", 32'(tx_bit), 1);

        // R6: starve then resume on the next boundary
        repeat (21) @(negedge clk);
        chk("R6 underrun after 6A", 32'(underrun), 1);
        chk("R6 held lsb of 6A", 32'(tx_bit), 0);
        wr_en   = 1'b1;
        wr_data = 8'h95;
        @(negedge clk);
        wr_en   = 1'b0;
        chk("R6 waits for boundary", 32'(tx_bit), 0);
        @(negedge clk);
        chk("R6 waits for boundary 2", 32'(tx_bit), 0);
        @(negedge clk);
        chk("R6 resume msb of 95", 32'(tx_bit), 1);
        chk("R6 underrun stays", 32'(underrun), 1);
        repeat (3) @(negedge clk);
        chk("R6 bit6 of 95", 32'(tx_bit), 0);

        // R7: drop enable in mid-byte, restart from bit 7
        tx_en = 1'b0;
        @(negedge clk);
        chk("R7 underrun cleared mid-byte", 32'(underrun), 0);
        chk("R7 bit held", 32'(tx_bit), 0);
        repeat (3) @(negedge clk);
        chk("R7 bit still held", 32'(tx_bit), 0);
        chk("R7 byte kept", 32'(ready), 1);
        tx_en = 1'b1;
        @(negedge clk);
        chk("R7 restart msb", 32'(tx_bit), 1);
        repeat (3) @(negedge clk);
        chk("R7 restart bit6", 32'(tx_bit), 0);
        repeat (3) @(negedge clk);
        chk("R7 restart bit5", 32'(tx_bit), 0);
        repeat (3) @(negedge clk);
        chk("R7 restart bit4", 32'(tx_bit), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule